// File: doc/BRIEF.md
# Parallel Attenuator Control Latch

This block produces the 6-bit control code for a step attenuator from six parallel control lines. Each bit of the code switches one attenuation stage, and the code equals twice the attenuation in dB. All inputs are asynchronous. They pass through a synchroniser into the system clock before any decision is made. Every input line also has a companion flag that marks the pin as undriven, so board-level pull-ups and pull-downs are modelled as logic defaults.

Two update behaviours share the same pins. In latched use, the strobe input rests low while the lines settle. A rising strobe then transfers the lines into the code register, but only when the lines were steady long enough before the edge, stay steady long enough after it, and the strobe stays high long enough. In direct use, the strobe rests high and the code follows the lines. The power-up code depends on the mode pin and the strobe level seen when reset is released. If parallel direct use is detected at power-up, the lines are loaded after a start-up delay. When the mode pin selects serial control, the code is fixed at its power-up value, because serial programming lives elsewhere. All timing windows are counters derived from a clock-frequency parameter.

Top module: `attnParallelLatch`

## Requirements
- R1: The mode is sampled once, shortly after reset is released. A low mode pin selects parallel control. A high mode pin, or a mode pin flagged as floating, selects serial control. Later changes on the mode pin have no effect on the code.
- R2: During reset, and in the cycles before the mode is sampled, the code is 63 (all ones, 31.5 dB). If the strobe is low or floating at power-up, the code stays 63 in both modes until a later update. In serial mode with the strobe high at power-up, the code becomes 0.
- R3: In parallel mode with the strobe high at power-up, the code holds 63 for BOOT_NS (4 µs at 200 MHz, 800 cycles) and then loads the control lines.
- R4: Code bit 5 down to bit 0 weigh 16, 8, 4, 2, 1 and 0.5 dB. A floating line reads 1 on code bits 5..3 and 0 on code bits 2..0, so all lines floating give 56 (28 dB).
- R5: In latched use, a strobe rising edge that passes all three timing checks loads the lines into the code. The load happens once the larger of the hold and pulse windows has elapsed. While the strobe is low, the code holds.
- R6: A strobe edge that arrives less than SETUP_NS (20 cycles) after the last line change is rejected, and the code is unchanged.
- R7: If the lines change within HOLD_NS (20 cycles) after an accepted strobe edge, the update is abandoned and the code is unchanged.
- R8: A strobe pulse shorter than PULSE_NS (6 cycles) is rejected, and the code is unchanged.
- R9: While the strobe stays high after a power-up load or a completed latch, the code follows the lines within a few cycles.
- R10: In serial mode, neither the strobe nor the lines ever change the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeSel | input | 1 | Mode pin: 0 selects parallel, 1 selects serial |
| modeFloat | input | 1 | Mode pin is undriven (reads as serial) |
| latchEn | input | 1 | Latch strobe, or direct-mode level |
| latchFloat | input | 1 | Strobe pin is undriven (reads as low) |
| ctrlLines | input | CODE_W | Parallel control lines; bit 5 is the 16 dB stage |
| lineFloat | input | CODE_W | Per-line undriven flags |
| attenCode | output | CODE_W | Registered attenuation code |

## Verification
The hardest case to reach from the ports is a strobe edge that passes the setup check and is then abandoned. Reaching it means the lines must move inside the hold window while the strobe is still high. The stimulus settles the lines for well over the setup window and raises the strobe. A few cycles later it moves the lines, then confirms after the window has closed that the old code survived. Short-pulse and early-edge rejections are reached the same way, by placing one input change a known number of cycles from the strobe edge. The direct power-up path is reached by resetting with the strobe high and sampling on either side of the start-up delay.

// File: rtl/attnCtlPkg.sv
`timescale 1ns/1ps
package attnCtlPkg;

  typedef enum logic [2:0] {
    PH_INIT,
    PH_BOOT,
    PH_IDLE,
    PH_ARM,
    PH_REJECT,
    PH_FOLLOW,
    PH_FROZEN
  } phase_t;

  typedef struct packed {
    logic captLines;
    logic loadCapt;
    logic loadLines;
    logic loadRef;
  } dpStrobe_t;

  function automatic int nsToCycles(int clkMhz, int ns);
    return (clkMhz * ns + 999) / 1000;
  endfunction

endpackage

// File: rtl/attnSync.sv
`timescale 1ns/1ps
module attnSync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);

  logic [STAGES-1:0][WIDTH-1:0] chain;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[0] <= '0;
        else       chain[0] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain[s] <= '0;
        else       chain[s] <= chain[s-1];
      end
    end
  end

  assign dout = chain[STAGES-1];

endmodule

// File: rtl/attnDatapath.sv
`timescale 1ns/1ps
module attnDatapath
  import attnCtlPkg::*;
#(
  parameter int                CODE_W      = 6,
  parameter logic [CODE_W-1:0] PULLUP_MASK = 6'b111000,
  parameter int                SETUP_CYC   = 20
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] rawLines,
  input  logic [CODE_W-1:0] lineFloat,
  input  dpStrobe_t         strobe,
  output logic [CODE_W-1:0] attenCode,
  output logic              linesMatch,
  output logic              setupOk
);

  localparam int                 CNT_W     = $clog2(SETUP_CYC + 1);
  localparam logic [CNT_W-1:0]   SETUP_LIM = CNT_W'(SETUP_CYC);

  logic [CODE_W-1:0] resolved;
  logic [CODE_W-1:0] prevLines;
  logic [CODE_W-1:0] captReg;
  logic [CODE_W-1:0] codeReg;
  logic [CNT_W-1:0]  stableCnt;

  // undriven pins take their pull value
  assign resolved = (rawLines & ~lineFloat) | (PULLUP_MASK & lineFloat);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevLines <= '0;
      stableCnt <= '0;
    end else begin
      prevLines <= resolved;
      if (resolved != prevLines)       stableCnt <= '0;
      else if (stableCnt != SETUP_LIM) stableCnt <= stableCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 captReg <= '0;
    else if (strobe.captLines) captReg <= resolved;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 codeReg <= '1;
    else if (strobe.loadRef)   codeReg <= '0;
    else if (strobe.loadCapt)  codeReg <= captReg;
    else if (strobe.loadLines) codeReg <= resolved;
  end

  assign setupOk    = (stableCnt == SETUP_LIM);
  assign linesMatch = (resolved == captReg);
  assign attenCode  = codeReg;

endmodule

// File: rtl/attnControl.sv
`timescale 1ns/1ps
module attnControl
  import attnCtlPkg::*;
#(
  parameter int INIT_CYC  = 3,
  parameter int BOOT_CYC  = 800,
  parameter int PULSE_CYC = 6,
  parameter int WIN_CYC   = 20
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      modeSelS,
  input  logic      modeFloatS,
  input  logic      latchEnS,
  input  logic      latchFloatS,
  input  logic      linesMatch,
  input  logic      setupOk,
  output dpStrobe_t strobe,
  output phase_t    phase
);

  localparam int MAX_CYC = (BOOT_CYC > WIN_CYC) ?
                           ((BOOT_CYC > INIT_CYC) ? BOOT_CYC : INIT_CYC) :
                           ((WIN_CYC > INIT_CYC) ? WIN_CYC : INIT_CYC);
  localparam int             CNT_W     = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] INIT_LIM  = CNT_W'(INIT_CYC - 1);
  localparam logic [CNT_W-1:0] BOOT_LIM  = CNT_W'(BOOT_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_LIM = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] WIN_LIM   = CNT_W'(WIN_CYC - 1);

  phase_t           nxtPhase;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNxt;
  logic             lePrev;
  logic             leLevel;
  logic             serialSel;
  logic             leRise;

  assign serialSel = modeSelS | modeFloatS;
  assign leLevel   = latchEnS & ~latchFloatS;
  assign leRise    = leLevel & ~lePrev;

  always_comb begin
    nxtPhase = phase;
    cntNxt   = cnt + 1'b1;
    strobe   = '0;
    unique case (phase)
      PH_INIT: begin
        if (cnt == INIT_LIM) begin
          cntNxt = '0;
          if (serialSel) begin
            nxtPhase       = PH_FROZEN;
            strobe.loadRef = leLevel;
          end else if (leLevel) begin
            nxtPhase = PH_BOOT;
          end else begin
            nxtPhase = PH_IDLE;
          end
        end
      end
      PH_BOOT: begin
        if (cnt == BOOT_LIM) begin
          cntNxt           = '0;
          strobe.loadLines = 1'b1;
          nxtPhase         = leLevel ? PH_FOLLOW : PH_IDLE;
        end
      end
      PH_IDLE: begin
        cntNxt = '0;
        if (leRise) begin
          if (setupOk) begin
            strobe.captLines = 1'b1;
            nxtPhase         = PH_ARM;
          end else begin
            nxtPhase = PH_REJECT;
          end
        end
      end
      PH_ARM: begin
        if (!linesMatch || (!leLevel && cnt < PULSE_LIM)) begin
          cntNxt   = '0;
          nxtPhase = leLevel ? PH_REJECT : PH_IDLE;
        end else if (cnt == WIN_LIM) begin
          cntNxt          = '0;
          strobe.loadCapt = 1'b1;
          nxtPhase        = leLevel ? PH_FOLLOW : PH_IDLE;
        end
      end
      PH_REJECT: begin
        cntNxt = '0;
        if (!leLevel) nxtPhase = PH_IDLE;
      end
      PH_FOLLOW: begin
        cntNxt = '0;
        if (leLevel) strobe.loadLines = 1'b1;
        else         nxtPhase         = PH_IDLE;
      end
      PH_FROZEN: cntNxt = '0;
      default: begin
        cntNxt   = '0;
        nxtPhase = PH_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_INIT;
      cnt    <= '0;
      lePrev <= 1'b0;
    end else begin
      phase  <= nxtPhase;
      cnt    <= cntNxt;
      lePrev <= leLevel;
    end
  end

endmodule

// File: rtl/attnParallelLatch.sv
`timescale 1ns/1ps
module attnParallelLatch
  import attnCtlPkg::*;
#(
  parameter int                CODE_W      = 6,
  parameter int                CLK_MHZ     = 200,
  parameter int                SETUP_NS    = 100,
  parameter int                HOLD_NS     = 100,
  parameter int                PULSE_NS    = 30,
  parameter int                BOOT_NS     = 4000,
  parameter int                SYNC_STAGES = 2,
  parameter logic [CODE_W-1:0] PULLUP_MASK = 6'b111000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeSel,
  input  logic              modeFloat,
  input  logic              latchEn,
  input  logic              latchFloat,
  input  logic [CODE_W-1:0] ctrlLines,
  input  logic [CODE_W-1:0] lineFloat,
  output logic [CODE_W-1:0] attenCode
);

  localparam int SETUP_CYC = nsToCycles(CLK_MHZ, SETUP_NS);
  localparam int HOLD_CYC  = nsToCycles(CLK_MHZ, HOLD_NS);
  localparam int PULSE_CYC = nsToCycles(CLK_MHZ, PULSE_NS);
  localparam int BOOT_CYC  = nsToCycles(CLK_MHZ, BOOT_NS);
  localparam int WIN_CYC   = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int INIT_CYC  = SYNC_STAGES + 1;
  localparam int SYNC_W    = 2 * CODE_W + 4;

  logic [SYNC_W-1:0] syncIn;
  logic [SYNC_W-1:0] syncOut;
  logic              modeSelS;
  logic              modeFloatS;
  logic              latchEnS;
  logic              latchFloatS;
  logic [CODE_W-1:0] linesS;
  logic [CODE_W-1:0] floatS;
  logic              linesMatch;
  logic              setupOk;
  dpStrobe_t         dpStrobe;
  phase_t            ctrlPhase;

  assign syncIn = {modeSel, modeFloat, latchEn, latchFloat, lineFloat, ctrlLines};
  assign {modeSelS, modeFloatS, latchEnS, latchFloatS, floatS, linesS} = syncOut;

  attnSync #(.WIDTH(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rstN (rstN),
    .din  (syncIn),
    .dout (syncOut)
  );

  attnControl #(
    .INIT_CYC  (INIT_CYC),
    .BOOT_CYC  (BOOT_CYC),
    .PULSE_CYC (PULSE_CYC),
    .WIN_CYC   (WIN_CYC)
  ) u_control (
    .clk         (clk),
    .rstN        (rstN),
    .modeSelS    (modeSelS),
    .modeFloatS  (modeFloatS),
    .latchEnS    (latchEnS),
    .latchFloatS (latchFloatS),
    .linesMatch  (linesMatch),
    .setupOk     (setupOk),
    .strobe      (dpStrobe),
    .phase       (ctrlPhase)
  );

  attnDatapath #(
    .CODE_W      (CODE_W),
    .PULLUP_MASK (PULLUP_MASK),
    .SETUP_CYC   (SETUP_CYC)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .rawLines   (linesS),
    .lineFloat  (floatS),
    .strobe     (dpStrobe),
    .attenCode  (attenCode),
    .linesMatch (linesMatch),
    .setupOk    (setupOk)
  );

endmodule

// File: rtl/attnParallelLatchChecker.sv
`timescale 1ns/1ps
module attnParallelLatchChecker
  import attnCtlPkg::*;
#(
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input phase_t            phase,
  input logic [CODE_W-1:0] attenCode
);

  // R2: code is at maximum until the mode has been sampled
  p_init_max_r2: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_INIT |-> attenCode == '1);

  // R3: maximum attenuation throughout the start-up delay
  p_boot_max_r3: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_BOOT |-> attenCode == '1);

  // R5: code holds while waiting for a strobe
  p_idle_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && $past(phase) == PH_IDLE) |-> $stable(attenCode));

  // R6: a rejected strobe does not touch the code
  p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    phase == PH_REJECT |=> $stable(attenCode));

  // R7: the code does not move while the hold window is open
  p_arm_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_ARM && $past(phase) == PH_ARM) |-> $stable(attenCode));

  // R10: serial mode never changes the code
  p_serial_frozen_r10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FROZEN && $past(phase) == PH_FROZEN) |-> $stable(attenCode));

endmodule

bind attnParallelLatch attnParallelLatchChecker #(.CODE_W(CODE_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .phase     (ctrlPhase),
  .attenCode (attenCode)
);

// File: tb/attnParallelLatch_bench.sv
`timescale 1ns/1ps
module attnParallelLatch_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       modeSel = 1'b0;
  logic       modeFloat = 1'b0;
  logic       latchEn = 1'b0;
  logic       latchFloat = 1'b0;
  logic [5:0] ctrlLines = '0;
  logic [5:0] lineFloat = '0;
  logic [5:0] attenCode;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  attnParallelLatch u_attnParallelLatch (
    .clk        (clk),
    .rstN       (rstN),
    .modeSel    (modeSel),
    .modeFloat  (modeFloat),
    .latchEn    (latchEn),
    .latchFloat (latchFloat),
    .ctrlLines  (ctrlLines),
    .lineFloat  (lineFloat),
    .attenCode  (attenCode)
  );

  task automatic check(string req, logic [5:0] got, logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: attenCode=%0d expected %0d", req, got, exp);
    end
  endtask

  task automatic waitCyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic powerUp(logic m, logic mf, logic le, logic lef,
                         logic [5:0] ln, logic [5:0] lf);
    @(negedge clk);
    rstN = 1'b0;
    modeSel = m; modeFloat = mf; latchEn = le; latchFloat = lef;
    ctrlLines = ln; lineFloat = lf;
    waitCyc(3);
    rstN = 1'b1;
    waitCyc(8);
  endtask

  task automatic latchPulse(int highCyc);
    latchEn = 1'b1;
    waitCyc(highCyc);
    latchEn = 1'b0;
  endtask

  task automatic testResetState();
    waitCyc(4);
    check("R2 reset value", attenCode, 6'd63);
  endtask

  task automatic testSerialPowerUp();
    powerUp(1'b1, 1'b0, 1'b1, 1'b0, 6'd9, 6'd0);
    check("R2 serial strobe high", attenCode, 6'd0);
    latchEn = 1'b0; ctrlLines = 6'd44; waitCyc(30);
    latchPulse(10); waitCyc(30);
    latchEn = 1'b1; waitCyc(30);
    ctrlLines = 6'd5; waitCyc(10);
    check("R10 serial ignores strobe and lines", attenCode, 6'd0);
    powerUp(1'b1, 1'b0, 1'b0, 1'b0, 6'd9, 6'd0);
    check("R2 serial strobe low", attenCode, 6'd63);
    ctrlLines = 6'd12; waitCyc(30);
    latchPulse(10); waitCyc(30);
    check("R10 serial keeps maximum", attenCode, 6'd63);
    powerUp(1'b0, 1'b1, 1'b1, 1'b0, 6'd9, 6'd0);
    check("R1 floating mode reads serial", attenCode, 6'd0);
  endtask

  task automatic testFloatingStrobe();
    powerUp(1'b0, 1'b0, 1'b1, 1'b1, 6'd5, 6'd0);
    waitCyc(850);
    check("R2 floating strobe gives maximum", attenCode, 6'd63);
  endtask

  task automatic testDirectBoot();
    powerUp(1'b0, 1'b0, 1'b1, 1'b0, 6'd23, 6'd0);
    waitCyc(400);
    check("R3 maximum during start-up delay", attenCode, 6'd63);
    waitCyc(420);
    check("R3 lines loaded after delay", attenCode, 6'd23);
    ctrlLines = 6'd9; waitCyc(6);
    check("R9 direct follows lines", attenCode, 6'd9);
  endtask

  task automatic testFloatingLines();
    powerUp(1'b0, 1'b0, 1'b1, 1'b0, 6'd0, 6'h3F);
    waitCyc(820);
    check("R4 all lines floating 28 dB", attenCode, 6'd56);
    powerUp(1'b0, 1'b0, 1'b1, 1'b0, 6'b101111, 6'b000111);
    waitCyc(820);
    check("R4 low lines float low", attenCode, 6'd40);
  endtask

  task automatic testLatchedCapture();
    powerUp(1'b0, 1'b0, 1'b0, 1'b0, 6'd5, 6'd0);
    check("R2 latched power-up maximum", attenCode, 6'd63);
    ctrlLines = 6'd37; waitCyc(30);
    latchEn = 1'b1; waitCyc(10);
    check("R5 no load inside window", attenCode, 6'd63);
    waitCyc(30);
    check("R5 18.5 dB loaded", attenCode, 6'd37);
    latchEn = 1'b0; waitCyc(5);
    ctrlLines = 6'd12; waitCyc(30);
    check("R5 holds while strobe low", attenCode, 6'd37);
    latchPulse(10); waitCyc(30);
    check("R5 pulse shorter than hold window", attenCode, 6'd12);
  endtask

  task automatic testSetupViolation();
    ctrlLines = 6'd50; waitCyc(5);
    latchPulse(10); waitCyc(40);
    check("R6 early edge rejected", attenCode, 6'd12);
    latchPulse(10); waitCyc(30);
    check("R5 later edge accepted", attenCode, 6'd50);
  endtask

  task automatic testHoldViolation();
    ctrlLines = 6'd33; waitCyc(30);
    latchEn = 1'b1; waitCyc(5);
    ctrlLines = 6'd7; waitCyc(5);
    latchEn = 1'b0; waitCyc(40);
    check("R7 change in hold window", attenCode, 6'd50);
  endtask

  task automatic testShortPulse();
    ctrlLines = 6'd20; waitCyc(30);
    latchPulse(2); waitCyc(40);
    check("R8 short pulse rejected", attenCode, 6'd50);
    latchPulse(10); waitCyc(30);
    check("R8 long pulse accepted", attenCode, 6'd20);
  endtask

  task automatic testDirectAfterLatch();
    latchEn = 1'b1; waitCyc(30);
    ctrlLines = 6'd44; waitCyc(6);
    check("R9 follows after latch", attenCode, 6'd44);
    ctrlLines = 6'd3; waitCyc(6);
    check("R9 follows second change", attenCode, 6'd3);
    latchEn = 1'b0; waitCyc(6);
    ctrlLines = 6'd60; waitCyc(10);
    check("R5 stops following when strobe low", attenCode, 6'd3);
  endtask

  task automatic testModeChangeIgnored();
    modeSel = 1'b1;
    ctrlLines = 6'd21; waitCyc(30);
    latchPulse(10); waitCyc(30);
    check("R1 mode change after reset ignored", attenCode, 6'd21);
    modeSel = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    testResetState();
    testSerialPowerUp();
    testFloatingStrobe();
    testDirectBoot();
    testFloatingLines();
    testLatchedCapture();
    testSetupViolation();
    testHoldViolation();
    testShortPulse();
    testDirectAfterLatch();
    testModeChangeIgnored();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule